// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This controller gathers 32 interrupt sources onto one interrupt request line for a processor. Software reaches it over a plain single-cycle register bus. Each source has a mode word with a 3-bit priority and a 2-bit trigger type, plus a 32-bit vector word. The block keeps a per-source enable bit, and software changes it through separate set and clear writes. A source is taken only while its priority is strictly greater than the level of the interrupt currently in service.

When the handler reads the claim register, the controller picks the best pending source: the highest priority, with the lowest source number winning a tie. It returns that source's vector and pushes the source's priority onto an eight-entry nesting stack. A read that finds nothing to claim returns the spurious vector instead and leaves the stack alone. A write to the end-of-service register pops one stack level and ignores its data.

The trigger type selects level or edge sensing. Edge sources capture a pending bit on the active edge. That bit is discarded by a claim or by a pending-clear write. Active-low level and falling-edge sensing are allowed only on sources marked as external by a parameter; on any other source those two codes fold to their active-high forms.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the enable mask reads 0 and irq_o is low. Every mode and vector word reads 0, and a claim read returns 0, which is the reset value of the spurious vector.
- R2: A write to the enable-set register (control index 2) sets each source whose data bit is 1. A write to enable-clear (index 3) clears each such source. Zero bits leave their source unchanged, and the mask register (index 4) reads back the current enables.
- R3: A write to pending-clear (index 5) drops the captured edge of every source whose data bit is 1, so a later claim read does not return that source.
- R4: The mode word at address 0x00+n holds the priority in bits [2:0] and the type in bits [5:4]. The type codes are 0 level-high, 1 rising edge, 2 level-low and 3 falling edge. With the default parameter, sources 29 to 31 are external. On internal sources, codes 2 and 3 are stored and read back as 0 and 1.
- R5: A write to the type-only alias at 0x60+n changes bits [5:4] of mode word n, with the same folding as R4, and leaves the priority unchanged.
- R6: irq_o is high, one clock after the state that causes it, exactly when an enabled pending source has a priority above the stack top, or when such a source exists and the stack is empty.
- R7: A claim read (control index 0, read data one cycle later) returns the vector word (0x20+n) of the qualifying source with the highest priority, lowest index on ties. It then pushes that priority.
- R8: A claim read with no qualifying source returns the spurious vector register (control index 1) and changes no state.
- R9: An edge source is pending from its active edge until it is claimed or cleared. A level source is pending while its input sits at the active level.
- R10: A write to end-of-service (control index 6), with any data, pops one level. On an empty stack it has no effect. Eight such writes unwind a full stack, letting a priority-0 source raise irq_o again.
- R11: A pending source whose priority equals the stack top does not raise irq_o and is not claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt source inputs |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 7 | Word address: [6:5] region (0 mode, 1 vector, 2 control, 3 type alias), [4:0] index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Directed patterns cover the following cases:
- Two equal-priority level sources, which tell the lowest-index tie rule apart from any other.
- A higher-priority rising edge arriving during service, which separates nesting from strict blocking.
- A repeat claim after that edge, which shows the captured edge is consumed.
- Active-low level and falling-edge sensing on external sources, alongside the folded codes on internal ones.
- An eight-level ladder that rises one priority at a time, which distinguishes a correct stack depth and an empty-stack pop from an off-by-one.

A seeded random phase then mixes input toggles, enable changes, mode rewrites, pending clears, claims and pops. Each result is compared against a bench model of the pending bits, the arbitration and the stack.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  typedef enum logic [1:0] {
    SRC_LVL_HI    = 2'd0,
    SRC_EDGE_RISE = 2'd1,
    SRC_LVL_LO    = 2'd2,
    SRC_EDGE_FALL = 2'd3
  } src_type_e;

  typedef enum logic [1:0] {
    RG_MODE = 2'd0,
    RG_VEC  = 2'd1,
    RG_CTL  = 2'd2,
    RG_TYPE = 2'd3
  } region_e;

  localparam int unsigned TYPE_LSB     = 4;
  localparam int unsigned CTL_CLAIM    = 0;
  localparam int unsigned CTL_SPU      = 1;
  localparam int unsigned CTL_EN_SET   = 2;
  localparam int unsigned CTL_EN_CLR   = 3;
  localparam int unsigned CTL_MASK     = 4;
  localparam int unsigned CTL_PEND_CLR = 5;
  localparam int unsigned CTL_EOI      = 6;
endpackage

// File: rtl/pvic_src_bank.sv
module pvic_src_bank
  import pvic_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned DATA_W = 32,
  parameter logic [N_SRC-1:0] EXT_MASK = '0,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [N_SRC-1:0]                  src_i,
  input  logic                              mode_we_i,
  input  logic                              type_we_i,
  input  logic                              vec_we_i,
  input  logic [IDX_W-1:0]                  idx_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  input  logic [N_SRC-1:0]                  en_set_i,
  input  logic [N_SRC-1:0]                  en_clr_i,
  input  logic [N_SRC-1:0]                  pend_clr_i,
  input  logic                              claim_i,
  input  logic [IDX_W-1:0]                  claim_idx_i,
  output logic [N_SRC-1:0]                  req_o,
  output logic [N_SRC-1:0]                  en_o,
  output logic [N_SRC-1:0][PRIO_W-1:0]      prio_o,
  output logic [N_SRC-1:0][DATA_W-1:0]      vec_o,
  output logic [DATA_W-1:0]                 mode_rd_o
);
  logic [N_SRC-1:0][1:0] type_w;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic [PRIO_W-1:0] prio_q;
    src_type_e         type_q;
    logic [DATA_W-1:0] vec_q;
    logic              en_q, lat_q, src_q;
    logic              sel, edge_hit, pend;
    logic [1:0]        type_in;

    assign sel = (idx_i == IDX_W'(g));
    // active-low codes fold on internal sources
    assign type_in = EXT_MASK[g] ? wdata_i[TYPE_LSB +: 2] : {1'b0, wdata_i[TYPE_LSB]};
    assign edge_hit = type_q[0] & (type_q[1] ? (src_q & ~src_i[g]) : (~src_q & src_i[g]));
    assign pend = type_q[0] ? lat_q : (src_i[g] ^ type_q[1]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_q <= '0;
        type_q <= SRC_LVL_HI;
        vec_q  <= '0;
        en_q   <= 1'b0;
        lat_q  <= 1'b0;
        src_q  <= 1'b0;
      end else begin
        src_q <= src_i[g];
        if (mode_we_i && sel) begin
          prio_q <= wdata_i[PRIO_W-1:0];
          type_q <= src_type_e'(type_in);
        end else if (type_we_i && sel) begin
          type_q <= src_type_e'(type_in);
        end
        if (vec_we_i && sel) vec_q <= wdata_i;
        if (en_set_i[g]) en_q <= 1'b1;
        else if (en_clr_i[g]) en_q <= 1'b0;
        lat_q <= (lat_q & ~(pend_clr_i[g] | (claim_i && claim_idx_i == IDX_W'(g)))) | edge_hit;
      end
    end

    assign req_o[g]  = en_q & pend;
    assign en_o[g]   = en_q;
    assign prio_o[g] = prio_q;
    assign vec_o[g]  = vec_q;
    assign type_w[g] = type_q;

    AST_TYPE_KEEPS_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (type_we_i && !mode_we_i && sel) |=> $stable(prio_q)); // R5
    AST_PEND_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_clr_i[g] && !edge_hit) |=> !lat_q); // R3
    if (!EXT_MASK[g]) begin : g_int
      AST_INT_NO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !type_q[1]); // R4
    end
  end

  always_comb begin
    mode_rd_o = '0;
    mode_rd_o[PRIO_W-1:0] = prio_o[idx_i];
    mode_rd_o[TYPE_LSB +: 2] = type_w[idx_i];
  end
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]             req_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                         found_o,
  output logic [IDX_W-1:0]             idx_o,
  output logic [PRIO_W-1:0]            prio_o
);
  // strict compare keeps the lowest index on ties
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && (!found_o || prio_i[i] > prio_o)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/pvic_stack.sv
module pvic_stack #(
  parameter int unsigned STK_D = 8,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned PTR_W = $clog2(STK_D),
  localparam int unsigned DEP_W = $clog2(STK_D + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic              pop_i,
  output logic              empty_o,
  output logic [PRIO_W-1:0] top_o
);
  logic [STK_D-1:0][PRIO_W-1:0] stk_q;
  logic [DEP_W-1:0]             dep_q;
  logic [DEP_W-1:0]             dep_m1;
  logic                         full;

  assign empty_o = (dep_q == '0);
  assign full    = (dep_q == DEP_W'(STK_D));
  assign dep_m1  = dep_q - DEP_W'(1);
  assign top_o   = stk_q[dep_m1[PTR_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stk_q <= '0;
      dep_q <= '0;
    end else if (push_i && !full) begin
      stk_q[dep_q[PTR_W-1:0]] <= push_prio_i;
      dep_q <= dep_q + DEP_W'(1);
    end else if (pop_i && !empty_o) begin
      dep_q <= dep_m1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full); // R11
  AST_NEST_STRICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !empty_o) |-> (push_prio_i > top_o)); // R11
  AST_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> empty_o); // R10
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import pvic_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned STK_D = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [N_SRC-1:0] EXT_MASK = 32'hE000_0000,
  localparam int unsigned IDX_W = $clog2(N_SRC),
  localparam int unsigned ADDR_W = IDX_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic                         rd, wr;
  region_e                      rg;
  logic [IDX_W-1:0]             sel;
  logic                         ctl_wr_spu, ctl_wr_set, ctl_wr_clr, ctl_wr_pclr, ctl_wr_eoi;
  logic                         rd_claim;
  logic [N_SRC-1:0]             req, en;
  logic [N_SRC-1:0][PRIO_W-1:0] prio;
  logic [N_SRC-1:0][DATA_W-1:0] vec;
  logic [DATA_W-1:0]            mode_rd;
  logic                         found, stk_empty, qualify, claim;
  logic [IDX_W-1:0]             win_idx;
  logic [PRIO_W-1:0]            win_prio, stk_top;
  logic [DATA_W-1:0]            spu_q, rdata_q, rd_mux;
  logic                         irq_q;

  assign rd  = bus_req_i & ~bus_we_i;
  assign wr  = bus_req_i & bus_we_i;
  assign rg  = region_e'(bus_addr_i[ADDR_W-1 -: 2]);
  assign sel = bus_addr_i[IDX_W-1:0];

  assign ctl_wr_spu  = wr && rg == RG_CTL && sel == IDX_W'(CTL_SPU);
  assign ctl_wr_set  = wr && rg == RG_CTL && sel == IDX_W'(CTL_EN_SET);
  assign ctl_wr_clr  = wr && rg == RG_CTL && sel == IDX_W'(CTL_EN_CLR);
  assign ctl_wr_pclr = wr && rg == RG_CTL && sel == IDX_W'(CTL_PEND_CLR);
  assign ctl_wr_eoi  = wr && rg == RG_CTL && sel == IDX_W'(CTL_EOI);
  assign rd_claim    = rd && rg == RG_CTL && sel == IDX_W'(CTL_CLAIM);

  pvic_src_bank #(
    .N_SRC(N_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .EXT_MASK(EXT_MASK)
  ) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src_i),
    .mode_we_i   (wr && rg == RG_MODE),
    .type_we_i   (wr && rg == RG_TYPE),
    .vec_we_i    (wr && rg == RG_VEC),
    .idx_i       (sel),
    .wdata_i     (bus_wdata_i),
    .en_set_i    (ctl_wr_set  ? bus_wdata_i[N_SRC-1:0] : '0),
    .en_clr_i    (ctl_wr_clr  ? bus_wdata_i[N_SRC-1:0] : '0),
    .pend_clr_i  (ctl_wr_pclr ? bus_wdata_i[N_SRC-1:0] : '0),
    .claim_i     (claim),
    .claim_idx_i (win_idx),
    .req_o       (req),
    .en_o        (en),
    .prio_o      (prio),
    .vec_o       (vec),
    .mode_rd_o   (mode_rd)
  );

  pvic_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .req_i   (req),
    .prio_i  (prio),
    .found_o (found),
    .idx_o   (win_idx),
    .prio_o  (win_prio)
  );

  pvic_stack #(.STK_D(STK_D), .PRIO_W(PRIO_W)) u_stk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (claim),
    .push_prio_i (win_prio),
    .pop_i       (ctl_wr_eoi),
    .empty_o     (stk_empty),
    .top_o       (stk_top)
  );

  assign qualify = found && (stk_empty || win_prio > stk_top);
  assign claim   = rd_claim && qualify;

  always_comb begin
    rd_mux = '0;
    unique case (rg)
      RG_MODE, RG_TYPE: rd_mux = mode_rd;
      RG_VEC:           rd_mux = vec[sel];
      RG_CTL: begin
        if (sel == IDX_W'(CTL_CLAIM))     rd_mux = qualify ? vec[win_idx] : spu_q;
        else if (sel == IDX_W'(CTL_SPU))  rd_mux = spu_q;
        else if (sel == IDX_W'(CTL_MASK)) rd_mux = DATA_W'(en);
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spu_q   <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (ctl_wr_spu) spu_q <= bus_wdata_i;
      if (rd) rdata_q <= rd_mux;
      irq_q <= qualify;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = irq_q;

  AST_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req) |=> !irq_o); // R6
  AST_SPU_ON_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_claim && !found) |=> (bus_rdata_o == $past(spu_q))); // R8
endmodule

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;
  localparam logic [31:0] EXT = 32'hE000_0000;
  localparam int A_CTL = 64;
  localparam int A_TYP = 96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #10 clk = ~clk;

  vec_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bit          m_en [32];
  bit   [2:0]  m_prio [32];
  bit   [1:0]  m_type [32];
  bit   [31:0] m_vec [32];
  bit          m_lat [32];
  bit   [31:0] m_src = '0;
  bit   [31:0] m_spu = '0;
  bit   [2:0]  m_stk [8];
  int          m_dep = 0;

  function automatic bit m_pend(int i);
    if (m_type[i][0]) return m_lat[i];
    return m_src[i] ^ m_type[i][1];
  endfunction

  function automatic int m_win();
    int b = -1;
    for (int i = 0; i < 32; i++)
      if (m_en[i] && m_pend(i) && (b < 0 || m_prio[i] > m_prio[b])) b = i;
    return b;
  endfunction

  function automatic bit m_qual();
    int w = m_win();
    if (w < 0) return 0;
    if (m_dep == 0) return 1;
    return m_prio[w] > m_stk[m_dep-1];
  endfunction

  function automatic bit [1:0] m_fix(int i, bit [1:0] t);
    return EXT[i] ? t : {1'b0, t[0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_op(bit w, int a, bit [31:0] d, output logic [31:0] r);
    @(negedge clk);
    req = 1'b1; we = w; addr = 7'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    r = rdata;
  endtask

  task automatic wr(int a, bit [31:0] d);
    logic [31:0] r;
    bus_op(1'b1, a, d, r);
    if (a < 32) begin m_prio[a] = d[2:0]; m_type[a] = m_fix(a, d[5:4]); end
    else if (a < 64) m_vec[a-32] = d;
    else if (a >= A_TYP) m_type[a-A_TYP] = m_fix(a-A_TYP, d[5:4]);
    else case (a - A_CTL)
      1: m_spu = d;
      2: for (int i = 0; i < 32; i++) if (d[i]) m_en[i] = 1;
      3: for (int i = 0; i < 32; i++) if (d[i]) m_en[i] = 0;
      5: for (int i = 0; i < 32; i++) if (d[i]) m_lat[i] = 0;
      6: if (m_dep > 0) m_dep--;
      default: ;
    endcase
  endtask

  task automatic rd_chk(string tag, int a, bit [31:0] exp);
    logic [31:0] r;
    bus_op(1'b0, a, 32'h0, r);
    chk(tag, r, exp);
  endtask

  task automatic claim(string tag);
    logic [31:0] r;
    int w = m_win();
    bit q = m_qual();
    bus_op(1'b0, A_CTL, 32'h0, r);
    chk(tag, r, q ? m_vec[w] : m_spu);
    if (q) begin m_stk[m_dep] = m_prio[w]; m_dep++; m_lat[w] = 0; end
  endtask

  task automatic set_src(bit [31:0] v);
    for (int i = 0; i < 32; i++)
      if (m_type[i][0] && (m_type[i][1] ? (m_src[i] && !v[i]) : (!m_src[i] && v[i])))
        m_lat[i] = 1;
    @(negedge clk);
    src = v; m_src = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_irq(string tag);
    @(negedge clk);
    chk(tag, {31'b0, irq}, {31'b0, m_qual()});
  endtask

  task automatic summary();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) begin
      m_en[i] = 0; m_prio[i] = 0; m_type[i] = 0; m_vec[i] = 0; m_lat[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd_chk("R1 mask", A_CTL + 4, 32'h0);
    rd_chk("R1 mode", 5, 32'h0);
    rd_chk("R1 vector", 32 + 5, 32'h0);
    claim("R1 claim");

    // R8 spurious vector
    wr(A_CTL + 1, 32'hDEAD_0001);
    claim("R8 spurious");
    rd_chk("R8 spu readback", A_CTL + 1, 32'hDEAD_0001);

    // R2 set/clear enables
    wr(A_CTL + 2, 32'h0000_00F0);
    wr(A_CTL + 2, 32'h0000_0001);
    rd_chk("R2 mask set", A_CTL + 4, 32'h0000_00F1);
    wr(A_CTL + 3, 32'h0000_0010);
    rd_chk("R2 mask clr", A_CTL + 4, 32'h0000_00E1);
    wr(A_CTL + 3, 32'hFFFF_FFFF);
    rd_chk("R2 mask zero", A_CTL + 4, 32'h0);

    // R4 mode layout and folding
    wr(30, 32'h25);
    rd_chk("R4 ext low", 30, 32'h25);
    wr(3, 32'h25);
    rd_chk("R4 int fold low", 3, 32'h05);
    wr(3, 32'h35);
    rd_chk("R4 int fold fall", 3, 32'h15);
    wr(29, 32'h37);
    rd_chk("R4 ext fall", 29, 32'h37);

    // R5 type-only alias
    wr(A_TYP + 30, 32'h30);
    rd_chk("R5 keep prio", 30, 32'h35);
    wr(A_TYP + 3, 32'h20);
    rd_chk("R5 keep prio fold", 3, 32'h05);

    // nesting setup
    for (int i = 0; i < 32; i++) wr(32 + i, 32'd100 + 32'(i));
    wr(1, 32'h02); wr(2, 32'h02); wr(3, 32'h00); wr(4, 32'h16);
    wr(29, 32'h00); wr(30, 32'h00);
    wr(A_CTL + 2, 32'h0000_0016);
    set_src(32'h6);
    chk_irq("R6 irq raise");
    claim("R7 tie lowest index");
    chk_irq("R11 equal prio blocked");
    set_src(32'h16);
    chk_irq("R9 edge pending");
    claim("R7 nested higher");
    claim("R9 edge consumed");
    chk_irq("R6 irq low in service");
    wr(A_CTL + 6, 32'hFFFF_FFFF);
    chk_irq("R11 equal after pop");
    wr(A_CTL + 6, 32'h0);
    chk_irq("R10 pop to empty");

    // R3 pending clear
    set_src(32'h06);
    set_src(32'h16);
    wr(A_CTL + 5, 32'h0000_0010);
    claim("R3 level wins");
    claim("R3 edge gone");
    wr(A_CTL + 6, 32'h0);

    // external level-low and falling edge
    wr(A_CTL + 3, 32'hFFFF_FFFF);
    wr(31, 32'h24);
    wr(A_CTL + 2, 32'h8000_0000);
    chk_irq("R9 level low pending");
    claim("R9 level low claim");
    set_src(m_src | 32'h8000_0000);
    wr(A_CTL + 6, 32'h0);
    chk_irq("R9 level low idle");
    wr(30, 32'h37);
    wr(A_CTL + 2, 32'h4000_0000);
    set_src(m_src | 32'h4000_0000);
    chk_irq("R9 no fall yet");
    set_src(m_src & ~32'h4000_0000);
    claim("R9 falling claim");
    wr(A_CTL + 6, 32'h0);

    // R10 full ladder
    wr(A_CTL + 3, 32'hFFFF_FFFF);
    wr(A_CTL + 5, 32'hFFFF_FFFF);
    set_src(32'h0);
    for (int p = 0; p < 8; p++) wr(8 + p, 32'(p));
    for (int p = 0; p < 8; p++) begin
      wr(A_CTL + 2, 32'h1 << (8 + p));
      set_src(m_src | (32'h1 << (8 + p)));
      claim("R10 ladder claim");
    end
    chk_irq("R10 full stack idle");
    set_src(32'h0000_0100);
    for (int k = 0; k < 7; k++) wr(A_CTL + 6, 32'h0);
    chk_irq("R10 seven pops");
    wr(A_CTL + 6, 32'h0);
    chk_irq("R10 eighth pop releases");
    wr(A_CTL + 6, 32'h0);
    chk_irq("R10 pop on empty");
    claim("R10 claim after unwind");
    wr(A_CTL + 6, 32'h0);

    // random phase
    wr(A_CTL + 3, 32'hFFFF_FFFF);
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 7);
      int s = $urandom_range(0, 31);
      case (op)
        0, 1: set_src(m_src ^ (32'h1 << s));
        2: wr(A_CTL + 2, $urandom());
        3: wr(A_CTL + 3, $urandom());
        4: wr(s, {26'b0, 2'($urandom()), 1'b0, 3'($urandom())});
        5: claim("R7 random claim");
        6: wr(A_CTL + 6, $urandom());
        default: wr(A_CTL + 5, $urandom());
      endcase
      chk_irq("R6 random irq");
    end

    summary();
  end
endmodule